// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This core is the countdown engine of a system watchdog. It runs from a fixed 33 MHz reference clock. Software brings it to life with a rising edge on the enable input. It then counts a first timeout derived from a 20-bit stage-one preload. If software does not ping it in time, the first expiry raises a one-cycle interrupt request of a configurable kind. The counter then reloads with the stage-two timeout. If that second period also runs out, the core can ask for a system reset. In that case it records, in a flag that a normal device reset does not clear, that the watchdog was the cause.

Each preload is scaled by a prescale shift. The shift is 15 bits for the slow tick of about 1 kHz and 5 bits for the fast tick of about 1 MHz. When the reset path is disabled, a free-run option starts stage one again after stage two expires. The register file and the unlock sequence sit outside this core and drive its inputs directly.

Top module: `wdog_two_stage`

## Requirements
- R1: While rst_n is low at a clock edge, the core returns to its idle state. Stage one is selected, nothing is armed and no pulse is issued. After a power-up reset (por_n low) every output is low.
- R2: A stage lasts T reference cycles. T is the preload shifted left by 5 when fast_sel is 1, or by 15 when fast_sel is 0. A preload of zero gives T = 1. The stage-one expiry is visible T cycles after the clock edge that samples the enable rise.
- R3: Stage-one expiry produces a one-cycle pulse that depends on irq_type. Code 0 drives irq_pulse, code 2 drives smi_pulse, and codes 1 and 3 produce no pulse.
- R4: After stage-one expiry, stage two runs for the timeout of pre_two. Its expiry falls T1 + T2 cycles after the start edge.
- R5: When stage two expires with reboot_en at 1, reset_req pulses for one cycle and reboot_flag becomes 1 in the next cycle. The core then goes idle. Neither ping nor a still-high enable restarts it until enable falls and rises again.
- R6: When stage two expires with reboot_en at 0, free_run decides what follows. With free_run at 1, stage one restarts and expires again T1 cycles later. With free_run at 0, the core stops and emits nothing further.
- R7: A rising edge of en starts stage one. While en is low the core emits no pulse, and dropping en mid-stage cancels the countdown.
- R8: A ping taken while the core is running, or stopped but still enabled and not rebooted, restarts stage one with a full T1. A ping while en is low has no effect.
- R9: reboot_flag holds its value through rst_n. It is cleared only by por_n or by flag_clr. A set and a clear in the same cycle leave the flag set.
- R10: In any cycle, at most one of irq_pulse, smi_pulse and reset_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 33 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| por_n | input | 1 | Synchronous active-low power-up reset, also clears reboot_flag |
| en | input | 1 | Watchdog enable; a rising edge starts stage one |
| ping | input | 1 | Keep-alive; restarts stage one |
| flag_clr | input | 1 | Clears reboot_flag |
| pre_one | input | 20 | Stage-one preload |
| pre_two | input | 20 | Stage-two preload |
| fast_sel | input | 1 | 1 selects the 5-bit shift, 0 selects the 15-bit shift |
| irq_type | input | 2 | Stage-one action: 0 irq, 2 smi, 1/3 none |
| reboot_en | input | 1 | Allows a reset request at stage-two expiry |
| free_run | input | 1 | Restarts stage one after stage two when no reset is requested |
| irq_pulse | output | 1 | One-cycle normal interrupt request |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |
| reset_req | output | 1 | One-cycle system reset request |
| reboot_flag | output | 1 | Sticky record that the watchdog caused a reset |

## Verification
Runs use small fast-scale preloads, including zero, under every interrupt code and every combination of reboot and free-run, so the exact cycles of the stage-one and stage-two pulses separate the two shift amounts, the preload mux and the three endings of stage two. A single slow-scale run confirms the 15-bit shift. Mid-stage pings and enable drops show whether a restart reloads the full period or only cancels it. Pings after a reboot, and a device reset with the flag set, show whether the idle state after a reboot and the stickiness of the flag are kept.

// File: rtl/wdog_pkg.sv
// Shared types and codes for the two-stage watchdog core.
package wdog_pkg;

    typedef enum logic {
        STG_ONE = 1'b0,
        STG_TWO = 1'b1
    } wdog_stage_e;

    localparam logic [1:0] ACT_IRQ = 2'd0;
    localparam logic [1:0] ACT_SMI = 2'd2;

endpackage

// File: rtl/wdog_counter.sv
// Down-counter for one watchdog stage.
// Loads (preload << shift) - 1 and decrements to zero, where it stays.
// A preload of zero loads 0, so that stage lasts one cycle.
// Assumes that load and clear are never high in the same cycle.
module wdog_counter #(
    parameter int PRELOAD_W  = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 clear,
    input  logic [PRELOAD_W-1:0] preload,
    input  logic                 fast_sel,
    output logic                 at_zero
);
    localparam int MAX_SHIFT = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
    localparam int CNT_W     = PRELOAD_W + MAX_SHIFT + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    // Scaled stage length in reference cycles.
    always_comb begin
        if (fast_sel) span = CNT_W'(preload) << FAST_SHIFT;
        else          span = CNT_W'(preload) << SLOW_SHIFT;
    end

    // Load, clear or step the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= (span == '0) ? '0 : span - 1'b1;
        else if (clear)          cnt <= '0;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
// Stage sequencer for the watchdog.
// Tracks enable edges, the armed and running state and the current stage.
// Decides when the counter loads and which expiry action fires.
// Assumes at_zero comes from a counter that this block loads.
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ping,
    input  logic       at_zero,
    input  logic [1:0] irq_type,
    input  logic       reboot_en,
    input  logic       free_run,
    output logic       load,
    output logic       sel_two,
    output logic       clear,
    output logic       irq_p,
    output logic       smi_p,
    output logic       rst_p
);
    logic        en_q;
    logic        armed;
    logic        running;
    wdog_stage_e stage;

    logic start, expire, exp_one, exp_two, rerun;

    // Decode the events of this cycle.
    always_comb begin
        start   = (en & ~en_q) | (ping & en & armed);
        expire  = en & running & at_zero & ~start;
        exp_one = expire & (stage == STG_ONE);
        exp_two = expire & (stage == STG_TWO);
        rerun   = exp_two & ~reboot_en & free_run;
        load    = start | exp_one | rerun;
        sel_two = exp_one;
        clear   = ~en | (exp_two & ~rerun);
        irq_p   = exp_one & (irq_type == ACT_IRQ);
        smi_p   = exp_one & (irq_type == ACT_SMI);
        rst_p   = exp_two & reboot_en;
    end

    // Advance the enable history and the stage state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            armed   <= 1'b0;
            running <= 1'b0;
            stage   <= STG_ONE;
        end else begin
            en_q <= en;
            if (!en) begin
                armed   <= 1'b0;
                running <= 1'b0;
                stage   <= STG_ONE;
            end else if (start) begin
                armed   <= 1'b1;
                running <= 1'b1;
                stage   <= STG_ONE;
            end else if (exp_one) begin
                stage   <= STG_TWO;
            end else if (exp_two) begin
                stage   <= STG_ONE;
                running <= rerun;
                if (reboot_en) armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdog_flag.sv
// Sticky flag recording a watchdog-caused reset.
// Only the power-up reset or an explicit clear lowers it; a set wins over a clear.
module wdog_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag across device resets.
    always_ff @(posedge clk) begin
        if (!por_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/wdog_two_stage.sv
// Two-stage watchdog core: the sequencer, the counter and the sticky flag.
// Assumes clk is the 33 MHz reference and that every input is synchronous to it.
module wdog_two_stage #(
    parameter int PRELOAD_W  = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_n,
    input  logic                 en,
    input  logic                 ping,
    input  logic                 flag_clr,
    input  logic [PRELOAD_W-1:0] pre_one,
    input  logic [PRELOAD_W-1:0] pre_two,
    input  logic                 fast_sel,
    input  logic [1:0]           irq_type,
    input  logic                 reboot_en,
    input  logic                 free_run,
    output logic                 irq_pulse,
    output logic                 smi_pulse,
    output logic                 reset_req,
    output logic                 reboot_flag
);
    logic                 load, sel_two, clear, at_zero, rst_p;
    logic [PRELOAD_W-1:0] preload;

    // Pick the preload for the stage being loaded.
    assign preload = sel_two ? pre_two : pre_one;

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ping      (ping),
        .at_zero   (at_zero),
        .irq_type  (irq_type),
        .reboot_en (reboot_en),
        .free_run  (free_run),
        .load      (load),
        .sel_two   (sel_two),
        .clear     (clear),
        .irq_p     (irq_pulse),
        .smi_p     (smi_pulse),
        .rst_p     (rst_p)
    );

    wdog_counter #(
        .PRELOAD_W  (PRELOAD_W),
        .SLOW_SHIFT (SLOW_SHIFT),
        .FAST_SHIFT (FAST_SHIFT)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .clear    (clear),
        .preload  (preload),
        .fast_sel (fast_sel),
        .at_zero  (at_zero)
    );

    assign reset_req = rst_p;

    wdog_flag u_flag (
        .clk   (clk),
        .por_n (por_n),
        .set   (rst_p & rst_n),
        .clr   (flag_clr),
        .flag  (reboot_flag)
    );
endmodule

// File: rtl/wdog_two_stage_chk.sv
// Property checker bound to the watchdog top.
module wdog_two_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic en,
    input logic flag_clr,
    input logic irq_pulse,
    input logic smi_pulse,
    input logic reset_req,
    input logic reboot_flag
);
    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        irq_pulse |=> !irq_pulse);
    // R3
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        smi_pulse |=> !smi_pulse);
    // R5
    reboot_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        reset_req |=> reboot_flag);
    // R5
    reboot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        reset_req |=> !(irq_pulse || smi_pulse || reset_req));
    // R7
    en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !en |-> !(irq_pulse || smi_pulse || reset_req));
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reboot_flag && !flag_clr) |=> reboot_flag);
    // R9
    flag_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(reboot_flag) |-> $past(reset_req));
    // R10
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $onehot0({irq_pulse, smi_pulse, reset_req}));
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .en          (en),
    .flag_clr    (flag_clr),
    .irq_pulse   (irq_pulse),
    .smi_pulse   (smi_pulse),
    .reset_req   (reset_req),
    .reboot_flag (reboot_flag)
);

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n, por_n, en, ping, flag_clr, fast_sel, reboot_en, free_run;
    logic [19:0] pre_one, pre_two;
    logic [1:0]  irq_type;
    logic        irq_pulse, smi_pulse, reset_req, reboot_flag;

    int n_chk = 0;
    int n_fail = 0;
    int f_irq, f_smi, f_rst, c_irq, c_smi, c_rst;

    always #4 clk = ~clk;

    wdog_two_stage u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .en(en), .ping(ping),
        .flag_clr(flag_clr), .pre_one(pre_one), .pre_two(pre_two),
        .fast_sel(fast_sel), .irq_type(irq_type), .reboot_en(reboot_en),
        .free_run(free_run), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
        .reset_req(reset_req), .reboot_flag(reboot_flag)
    );

    function automatic int stage_len(int pre, bit fast);
        if (pre == 0) return 1;
        return fast ? (pre << 5) : (pre << 15);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic dev_reset(bit power);
        @(negedge clk);
        en = 0; ping = 0; flag_clr = 0; rst_n = 0;
        if (power) por_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1; por_n = 1;
    endtask

    task automatic start_run();
        @(negedge clk);
        en = 1;
    endtask

    // Watch n cycles; pulses are indexed by the posedges since the last drive.
    task automatic observe(int n, int ping_at, int drop_at);
        f_irq = 0; f_smi = 0; f_rst = 0; c_irq = 0; c_smi = 0; c_rst = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            ping = 0;
            if (irq_pulse) begin c_irq++; if (f_irq == 0) f_irq = i; end
            if (smi_pulse) begin c_smi++; if (f_smi == 0) f_smi = i; end
            if (reset_req) begin c_rst++; if (f_rst == 0) f_rst = i; end
            if (i == ping_at) ping = 1;
            if (i == drop_at) en = 0;
        end
    endtask

    task automatic config_set(int p1, int p2, bit fs, int it, bit rb, bit fr);
        pre_one = 20'(p1); pre_two = 20'(p2); fast_sel = fs;
        irq_type = 2'(it); reboot_en = rb; free_run = fr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t1, t2, it, p1, p2, n;
        bit rb, fr;
        en = 0; ping = 0; flag_clr = 0; rst_n = 0; por_n = 0;
        config_set(0, 0, 1, 0, 1, 0);
        void'($urandom(32'h1a2b));
        dev_reset(1);
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {irq_pulse, smi_pulse, reset_req, reboot_flag}, 0);

        // R2 R3 R4 R5: fast scale, irq, then reboot
        config_set(2, 1, 1, 0, 1, 0);
        start_run();
        observe(120, 0, 0);
        chk("R2 stage one length", f_irq, 64);
        chk("R3 irq count", c_irq, 1);
        chk("R4 stage two length", f_rst, 96);
        chk("R5 reset count", c_rst, 1);
        chk("R5 flag set", reboot_flag, 1);
        // R5 idle after reboot, pings ignored with en still high
        observe(200, 5, 0);
        chk("R5 idle after reboot", c_irq + c_smi + c_rst, 0);

        // R9 flag survives device reset, then cleared explicitly
        dev_reset(0);
        @(negedge clk);
        chk("R9 flag kept over rst_n", reboot_flag, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk("R9 flag cleared", reboot_flag, 0);

        // R2 zero preload, R3 smi, R6 stop without free run
        config_set(0, 3, 1, 2, 0, 0);
        start_run();
        observe(200, 0, 0);
        chk("R2 zero preload", f_smi, 1);
        chk("R3 smi only", c_irq, 0);
        chk("R6 stops once", c_smi, 1);
        chk("R6 no reset", c_rst + reboot_flag, 0);

        // R6 free run restarts stage one
        dev_reset(0);
        config_set(1, 2, 1, 0, 0, 1);
        start_run();
        observe(130, 0, 0);
        chk("R6 free run first", f_irq, 32);
        chk("R6 free run count", c_irq, 2);

        // R3 code 3 gives no pulse while timer still runs
        dev_reset(0);
        config_set(1, 1, 1, 3, 1, 0);
        start_run();
        observe(70, 0, 0);
        chk("R3 code 3 silent", c_irq + c_smi, 0);
        chk("R3 code 3 timer ran", f_rst, 64);
        dev_reset(1);

        // R8 ping restarts stage one
        config_set(2, 1, 1, 0, 0, 0);
        start_run();
        observe(120, 40, 0);
        chk("R8 ping restart", f_irq, 104);

        // R7 en drop cancels; R8 ping with en low ignored
        dev_reset(0);
        config_set(1, 1, 1, 0, 1, 0);
        start_run();
        observe(200, 0, 20);
        chk("R7 drop cancels", c_irq + c_rst, 0);
        observe(100, 5, 0);
        chk("R8 ping while off", c_irq + c_rst, 0);
        start_run();
        observe(40, 0, 0);
        chk("R7 restart on rise", f_irq, 32);

        // R2 slow scale
        dev_reset(1);
        config_set(1, 1, 0, 0, 0, 0);
        start_run();
        observe(32770, 0, 0);
        chk("R2 slow scale", f_irq, 32768);

        // Random runs against the requirement model
        for (int k = 0; k < 10; k++) begin
            dev_reset(1);
            p1 = $urandom_range(0, 3); p2 = $urandom_range(0, 3);
            it = $urandom_range(0, 3);
            rb = 1'($urandom_range(0, 1)); fr = 1'($urandom_range(0, 1));
            config_set(p1, p2, 1, it, rb, fr);
            t1 = stage_len(p1, 1); t2 = stage_len(p2, 1);
            n = 2 * t1 + t2;
            start_run();
            observe(n, 0, 0);
            chk("R3 rand irq", c_irq, (it == 0) ? ((!rb && fr) ? 2 : 1) : 0);
            chk("R3 rand smi", c_smi, (it == 2) ? ((!rb && fr) ? 2 : 1) : 0);
            chk("R4 rand reset", f_rst, rb ? t1 + t2 : 0);
            chk("R5 rand flag", reboot_flag, rb ? 1 : 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule